// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block arbitrates among thirteen level-sensitive interrupt request lines, numbered 1 to 13, and presents a single CPU interrupt level and an 8-bit vector number. Every source has an 8-bit control byte. Bits 4:0 of that byte form its arbitration weight, and bits 4:2 of it are also the CPU level. Bit 7 selects whether the vector is generated automatically from the level or taken from a vector register.

A pending register samples the request lines on every clock. A 16-bit mask register disables individual sources. On every cycle the arbiter picks the unmasked pending source with the heaviest weight, and the level and vector outputs are registered from that choice. Software reaches the control bytes, the mask, the pending image and three vector registers through a simple single-cycle register port: one write strobe and a combinational read.

Top module: `irq_prio_vectorer`

## Requirements
- R1: The pending register takes the state of each request line on every clock edge. It reads at address 0x3A with source n in bit n, and bit 0 always reads 0. Writes to 0x3A have no effect.
- R2: The 16-bit mask register at 0x36 is readable and writable, and it resets to 0x3FFE. Bit n set to 1 masks source n.
- R3: The control byte of source n is at address 0x13+n (0x14 to 0x20). At reset, sources 1 to 7 hold 4·n, source 8 holds 0x1C, sources 9 to 11 hold 0x80, and sources 12 and 13 hold 0x00.
- R4: An active source is one that is pending and unmasked. The winner is the active source whose control bits 4:0 are largest. On a tie, the lowest-numbered source wins.
- R5: If the winning weight is below 4, or if no source is active, the level and vector outputs are both 0.
- R6: The level output equals bits 4:2 of the winner's control byte.
- R7: When bit 7 of the winner's control byte is 1, the vector is 24 plus the level.
- R8: When bit 7 is 0, the vector comes from a register chosen by the source. Source 8 uses the watchdog vector at 0x42, which resets to 0x0F. Source 12 uses serial vector A at 0x44 and source 13 uses serial vector B at 0x45; both reset to 0x0F. Every other source gets 0x0F.
- R9: The level and vector outputs are registered. A register write shows on them one clock after the write edge. A request-line change shows two clock edges after it is applied: one edge for the pending sample and one for the output register.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | 13 | Request lines; bit n is source n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 16 | Write data; byte registers use bits 7:0 |
| reg_rdata_o | output | 16 | Combinational read data |
| irq_level_o | output | 3 | CPU interrupt level, 0 meaning none |
| irq_vector_o | output | 8 | Vector number for the current level |

## Verification
The hardest case to reach is a tie between two active sources with equal weights. The tie-break only shows when the two sources differ in their vector path. The stimulus raises sources 7 and 8 together, both at weight 0x1C, after the watchdog vector has been moved away from 0x0F, so that a wrong winner changes the vector seen at the port. Sub-threshold weights and the low two weight bits are reached in the same way: the bench rewrites control bytes so that a source that outranks another only through bits 1:0, or that sits below weight 4, decides the result.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 16;

    localparam logic [ADDR_W-1:0] CTRL_BASE = 8'h14;
    localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h36;
    localparam logic [ADDR_W-1:0] PEND_ADDR = 8'h3A;
    localparam logic [ADDR_W-1:0] WDV_ADDR  = 8'h42;
    localparam logic [ADDR_W-1:0] SERA_ADDR = 8'h44;
    localparam logic [ADDR_W-1:0] SERB_ADDR = 8'h45;

    localparam int unsigned WDOG_SRC = 8;
    localparam int unsigned SERA_SRC = 12;
    localparam int unsigned SERB_SRC = 13;

    localparam logic [15:0] MASK_RST    = 16'h3FFE;
    localparam logic [7:0]  VEC_RST     = 8'h0F;
    localparam logic [7:0]  VEC_DEFAULT = 8'h0F;
    localparam logic [7:0]  AUTO_BASE   = 8'd24;
    localparam logic [4:0]  MIN_WEIGHT  = 5'd4;

    typedef struct packed {
        logic [2:0] level;
        logic [7:0] vector;
    } irqc_out_t;

    function automatic logic [7:0] ctrl_reset(int unsigned n);
        if (n >= 1 && n <= 7)       return 8'(n * 4);
        else if (n == 8)            return 8'h1C;
        else if (n >= 9 && n <= 11) return 8'h80;
        else                        return 8'h00;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC:1]              src_req_i,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic [NUM_SRC:1][7:0]         ctrl_o,
    output logic [15:0]                   mask_o,
    output logic [NUM_SRC:1]              pend_o,
    output logic [7:0]                    wdv_o,
    output logic [7:0]                    sera_o,
    output logic [7:0]                    serb_o
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC - 1;

    typedef struct packed {
        logic [NUM_SRC:1][7:0] ctrl;
        logic [15:0]           mask;
        logic [NUM_SRC:1]      pend;
        logic [7:0]            wdv;
        logic [7:0]            sera;
        logic [7:0]            serb;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.pend = src_req_i;
        if (wr_i) begin
            unique case (addr_i)
                MASK_ADDR: regs_d.mask = wdata_i;
                WDV_ADDR:  regs_d.wdv  = wdata_i[7:0];
                SERA_ADDR: regs_d.sera = wdata_i[7:0];
                SERB_ADDR: regs_d.serb = wdata_i[7:0];
                default: begin
                    for (int n = 1; n <= NUM_SRC; n++) begin
                        if (addr_i == ADDR_W'(int'(CTRL_BASE) + n - 1))
                            regs_d.ctrl[n] = wdata_i[7:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 1; n <= NUM_SRC; n++)
                regs_q.ctrl[n] <= ctrl_reset(n);
            regs_q.mask <= MASK_RST;
            regs_q.pend <= '0;
            regs_q.wdv  <= VEC_RST;
            regs_q.sera <= VEC_RST;
            regs_q.serb <= VEC_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            MASK_ADDR: rdata_o = regs_q.mask;
            PEND_ADDR: rdata_o = {{PAD_W{1'b0}}, regs_q.pend, 1'b0};
            WDV_ADDR:  rdata_o = {8'h00, regs_q.wdv};
            SERA_ADDR: rdata_o = {8'h00, regs_q.sera};
            SERB_ADDR: rdata_o = {8'h00, regs_q.serb};
            default: begin
                for (int n = 1; n <= NUM_SRC; n++) begin
                    if (addr_i == ADDR_W'(int'(CTRL_BASE) + n - 1))
                        rdata_o = {8'h00, regs_q.ctrl[n]};
                end
            end
        endcase
    end

    assign ctrl_o = regs_q.ctrl;
    assign mask_o = regs_q.mask;
    assign pend_o = regs_q.pend;
    assign wdv_o  = regs_q.wdv;
    assign sera_o = regs_q.sera;
    assign serb_o = regs_q.serb;

    // R1
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (regs_q.pend == $past(src_req_i)));

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == MASK_ADDR) |=> (regs_q.mask == $past(wdata_i)));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned NUM_SRC = 13,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC:1][7:0] ctrl_i,
    input  logic [NUM_SRC:1]      pend_i,
    input  logic [15:0]           mask_i,
    output logic [IDX_W-1:0]      win_idx_o,
    output logic [4:0]            win_val_o
);

    logic [4:0]       best_val [0:NUM_SRC];
    logic [IDX_W-1:0] best_idx [0:NUM_SRC];
    logic [NUM_SRC:1] active;

    assign best_val[0] = '0;
    assign best_idx[0] = '0;

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_stage
        logic take;
        assign active[g]   = pend_i[g] & ~mask_i[g];
        assign take        = active[g] && (ctrl_i[g][4:0] > best_val[g-1]);
        assign best_val[g] = take ? ctrl_i[g][4:0] : best_val[g-1];
        assign best_idx[g] = take ? IDX_W'(g)      : best_idx[g-1];

        // R4
        weight_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            active[g] |-> (ctrl_i[g][4:0] <= win_val_o));

        // R4
        tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (active[g] && ctrl_i[g][4:0] == win_val_o && win_val_o != 5'd0)
                |-> (win_idx_o <= IDX_W'(g)));
    end

    assign win_val_o = best_val[NUM_SRC];
    assign win_idx_o = best_idx[NUM_SRC];

endmodule

// File: rtl/irqc_outgen.sv
module irqc_outgen
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC:1][7:0] ctrl_i,
    input  logic [IDX_W-1:0]      win_idx_i,
    input  logic [4:0]            win_val_i,
    input  logic [7:0]            wdv_i,
    input  logic [7:0]            sera_i,
    input  logic [7:0]            serb_i,
    output logic [2:0]            level_o,
    output logic [7:0]            vector_o
);

    irqc_out_t out_d, out_q;
    logic [7:0] win_ctrl;

    always_comb begin
        win_ctrl = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (win_idx_i == IDX_W'(n))
                win_ctrl = ctrl_i[n];
        end
    end

    always_comb begin
        out_d = '0;
        if (win_val_i >= MIN_WEIGHT) begin
            out_d.level = win_ctrl[4:2];
            if (win_ctrl[7]) begin
                out_d.vector = AUTO_BASE + {5'b0, win_ctrl[4:2]};
            end else if (win_idx_i == IDX_W'(WDOG_SRC)) begin
                out_d.vector = wdv_i;
            end else if (win_idx_i == IDX_W'(SERA_SRC)) begin
                out_d.vector = sera_i;
            end else if (win_idx_i == IDX_W'(SERB_SRC)) begin
                out_d.vector = serb_i;
            end else begin
                out_d.vector = VEC_DEFAULT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign level_o  = out_q.level;
    assign vector_o = out_q.vector;

    // R5
    quiet_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_val_i) < MIN_WEIGHT) |-> (out_q.level == 3'd0 && out_q.vector == 8'd0));

    // R7
    autovec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.level != 3'd0 && $past(win_ctrl[7]))
            |-> (out_q.vector == AUTO_BASE + {5'b0, out_q.level}));

endmodule

// File: rtl/irq_prio_vectorer.sv
module irq_prio_vectorer
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   src_req_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [2:0]         irq_level_o,
    output logic [7:0]         irq_vector_o
);

    logic [NUM_SRC:1][7:0] ctrl;
    logic [15:0]           mask;
    logic [NUM_SRC:1]      pend;
    logic [7:0]            wdv, sera, serb;
    logic [IDX_W-1:0]      win_idx;
    logic [4:0]            win_val;

    irqc_regs #(.NUM_SRC(NUM_SRC)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req_i(src_req_i),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .ctrl_o   (ctrl),
        .mask_o   (mask),
        .pend_o   (pend),
        .wdv_o    (wdv),
        .sera_o   (sera),
        .serb_o   (serb)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC)) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_i   (ctrl),
        .pend_i   (pend),
        .mask_i   (mask),
        .win_idx_o(win_idx),
        .win_val_o(win_val)
    );

    irqc_outgen #(.NUM_SRC(NUM_SRC)) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_i   (ctrl),
        .win_idx_i(win_idx),
        .win_val_i(win_val),
        .wdv_i    (wdv),
        .sera_i   (sera),
        .serb_i   (serb),
        .level_o  (irq_level_o),
        .vector_o (irq_vector_o)
    );

endmodule

// File: tb/test_irq_prio_vectorer.sv
module test_irq_prio_vectorer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] src_req = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  m_ctrl [1:13];
    logic [15:0] m_mask;
    logic [7:0]  m_wdv, m_sa, m_sb;

    always #2 clk = ~clk;

    irq_prio_vectorer i_irq_prio_vectorer (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_level_o (irq_level),
        .irq_vector_o(irq_vector)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 8'h36) m_mask = d;
        else if (a == 8'h42) m_wdv = d[7:0];
        else if (a == 8'h44) m_sa = d[7:0];
        else if (a == 8'h45) m_sb = d[7:0];
        else if (a >= 8'h14 && a <= 8'h20) m_ctrl[a - 8'h13] = d[7:0];
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [15:0] exp);
        reg_addr = a;
        #1;
        check(tag, $sformatf("read 0x%0h", a), reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [10:0] model();
        logic [4:0] best = 0;
        int idx = 0;
        logic [2:0] lvl;
        logic [7:0] vec;
        for (int i = 1; i <= 13; i++)
            if (src_req[i] && !m_mask[i] && m_ctrl[i][4:0] > best) begin
                best = m_ctrl[i][4:0]; idx = i;
            end
        if (best < 4) return 11'd0;
        lvl = m_ctrl[idx][4:2];
        if (m_ctrl[idx][7]) vec = 8'd24 + 8'(lvl);
        else if (idx == 8)  vec = m_wdv;
        else if (idx == 12) vec = m_sa;
        else if (idx == 13) vec = m_sb;
        else                vec = 8'h0F;
        return {lvl, vec};
    endfunction

    task automatic out_chk(string tag, int lvl, int vec);
        logic [10:0] m = model();
        check(tag, "level", irq_level, lvl);
        check(tag, "vector", irq_vector, vec);
        check(tag, "model level", irq_level, m[10:8]);
        check(tag, "model vector", irq_vector, m[7:0]);
    endtask

    task automatic t_reset();
        for (int n = 1; n <= 7; n++) rd_chk("R3", 8'(8'h13 + n), 16'(n * 4));
        rd_chk("R3", 8'h1B, 16'h001C);
        rd_chk("R3", 8'h1C, 16'h0080);
        rd_chk("R3", 8'h1E, 16'h0080);
        rd_chk("R3", 8'h1F, 16'h0000);
        rd_chk("R3", 8'h20, 16'h0000);
        rd_chk("R2", 8'h36, 16'h3FFE);
        rd_chk("R8", 8'h42, 16'h000F);
        rd_chk("R1", 8'h3A, 16'h0000);
        out_chk("R5", 0, 0);
    endtask

    task automatic t_single();
        wr(8'h36, 16'h0000);
        src_req[7] = 1'b1;
        settle();
        rd_chk("R1", 8'h3A, 16'h0080);
        out_chk("R6", 7, 8'h0F);
    endtask

    task automatic t_tie();
        wr(8'h42, 16'h0040);
        src_req[8] = 1'b1;
        settle();
        out_chk("R4", 7, 8'h0F);
        src_req[7] = 1'b0;
        settle();
        out_chk("R8", 7, 8'h40);
        src_req[8] = 1'b0;
        settle();
        out_chk("R5", 0, 0);
    endtask

    task automatic t_auto();
        src_req[9] = 1'b1;
        settle();
        out_chk("R5", 0, 0);
        wr(8'h1C, 16'h0094);
        settle();
        out_chk("R7", 5, 29);
        src_req[9] = 1'b0;
    endtask

    task automatic t_serial();
        wr(8'h44, 16'h0055);
        wr(8'h45, 16'h0066);
        wr(8'h1F, 16'h0018);
        wr(8'h20, 16'h0018);
        src_req[12] = 1'b1; src_req[13] = 1'b1;
        settle();
        out_chk("R8", 6, 8'h55);
        src_req[12] = 1'b0;
        settle();
        out_chk("R8", 6, 8'h66);
        src_req[13] = 1'b0;
    endtask

    task automatic t_low_bits();
        wr(8'h14, 16'h000D);
        wr(8'h15, 16'h000E);
        src_req[1] = 1'b1; src_req[2] = 1'b1;
        settle();
        out_chk("R4", 3, 8'h0F);
        wr(8'h15, 16'h0003);
        wr(8'h14, 16'h0002);
        settle();
        out_chk("R5", 0, 0);
        src_req[1] = 1'b0; src_req[2] = 1'b0;
    endtask

    task automatic t_mask_timing();
        src_req[3] = 1'b1; src_req[6] = 1'b1;
        settle();
        out_chk("R4", 6, 8'h0F);
        wr(8'h36, 16'h0040);
        check("R9", "level before update", irq_level, 6);
        @(negedge clk);
        check("R2", "level after mask", irq_level, 3);
        src_req[3] = 1'b0;
        @(negedge clk);
        check("R9", "level one edge after req drop", irq_level, 3);
        @(negedge clk);
        check("R9", "level two edges after req drop", irq_level, 0);
        src_req[6] = 1'b0;
    endtask

    task automatic t_ignored();
        wr(8'h3A, 16'hFFFF);
        src_req[5] = 1'b1;
        settle();
        rd_chk("R1", 8'h3A, 16'h0020);
        out_chk("R1", 5, 8'h0F);
        wr(8'h60, 16'hFFFF);
        rd_chk("R10", 8'h60, 16'h0000);
        rd_chk("R10", 8'h36, 16'h0040);
        rd_chk("R10", 8'h42, 16'h0040);
        src_req[5] = 1'b0;
    endtask

    initial begin
        for (int n = 1; n <= 13; n++)
            m_ctrl[n] = (n <= 7) ? 8'(n * 4) : (n == 8) ? 8'h1C : (n <= 11) ? 8'h80 : 8'h00;
        m_mask = 16'h3FFE; m_wdv = 8'h0F; m_sa = 8'h0F; m_sb = 8'h0F;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_tie();
        t_auto();
        t_serial();
        t_low_bits();
        t_mask_timing();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule